// File: doc/BRIEF.md
# Byte/Word Logic and Shift Execution Unit

This block is the bitwise and shift execution stage of a 16-bit processor datapath. When `start` is high it accepts an opcode, a byte-or-word size select, a destination operand, a source operand, a count selection and the incoming flag vector. It returns a result, a write-enable for that result and an updated flag vector. Operand fetch, memory access and instruction decode sit elsewhere and are not part of this block.

The bitwise operations AND, OR, XOR, NOT and TEST finish one cycle after they are accepted. TEST updates the flags only and raises no write-enable.

Shifts and rotates move one bit position per clock. The step count is either the constant 1 or the low five bits of a count register. A single-cycle `done` pulse marks the cycle in which the result, write-enable and flags are valid. The result and flags hold until the next completion. While a multi-cycle operation runs, `busy` is high and any new `start` is ignored.

Top module: `bitop_shift_unit`

## Requirements
- R1: Opcodes 0 (AND), 1 (OR) and 2 (XOR) combine `dst_in` with `src_in` bit by bit. `result` carries the combined value, and `done` and `wr_en` are high in the cycle after the start cycle.
- R2: Opcode 3 (NOT) returns the bitwise complement of `dst_in` with `wr_en` high. `flags_out` equals `flags_in` unchanged.
- R3: Opcode 4 (TEST) forms the bitwise AND and updates the flags like AND. `wr_en` stays low in its `done` cycle.
- R4: For AND, OR, XOR and TEST, the flag bits are set as follows. The flag vector layout is bit0 = carry, bit1 = parity, bit2 = zero, bit3 = sign, bit4 = overflow.
  - Carry and overflow are cleared.
  - Zero is set when the sized result is zero.
  - Sign is the result MSB.
  - Parity is 1 when the low 8 result bits hold an even number of ones.
- R5: Opcodes 5 and 6 are identical left shifts. Each step inserts 0 at the LSB and moves the old MSB into carry.
- R6: Opcode 7 is a logical right shift. Each step inserts 0 at the MSB and moves the old LSB into carry.
- R7: Opcode 8 is an arithmetic right shift. Each step keeps the old MSB in place and moves the LSB into carry.
- R8: Opcodes 9 (rotate left) and 10 (rotate right) behave as follows. A left step puts the old MSB into both the LSB and carry. A right step puts the old LSB into both the MSB and carry.
- R9: Opcodes 11 and 12 rotate through carry. A left step moves the MSB into carry and the previous carry into the LSB. A right step moves the LSB into carry and the previous carry into the MSB. The initial carry is `flags_in` bit0.
- R10: With `is_word` = 0, the operation uses bits 7:0 with bit 7 as the MSB, and `result[15:8]` is 0. With `is_word` = 1, it uses all 16 bits with bit 15 as the MSB.
- R11: The step count n is 1 when `cnt_sel` = 0 and `cnt_reg[4:0]` when `cnt_sel` = 1. A shift or rotate with n > 0 raises `busy` and applies one step per clock. Its `done` (with `wr_en`) comes n+1 cycles after the start cycle, and `done` stays low before then. A `start` while `busy` is ignored.
- R12: A shift or rotate with n = 0 completes in the next cycle. Its result is `dst_in` cut to size, `flags_out` equals `flags_in`, and `wr_en` is high.
- R13: After a shift or rotate with n > 0, the flags are set as follows.
  - Carry holds the last bit moved out.
  - When n = 1, overflow is final MSB XOR carry for opcodes 5, 6, 9 and 11, and the XOR of the top two result bits for opcodes 7, 8, 10 and 12. For other n, overflow comes from `flags_in`.
  - The shifts (5 to 8) set zero, sign and parity from the result as in R4. The rotates keep these three from `flags_in`.
- R14: Opcodes 13 to 15 complete in the next cycle. The result is `dst_in` cut to size, the flags are unchanged, and `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept an operation this cycle (ignored while busy) |
| op | input | 4 | Operation code |
| is_word | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| dst_in | input | 16 | Destination operand |
| src_in | input | 16 | Source operand for AND/OR/XOR/TEST |
| cnt_sel | input | 1 | 0 = count of 1, 1 = count from cnt_reg |
| cnt_reg | input | 8 | Count register value (low 5 bits used) |
| flags_in | input | 5 | Incoming flags {OF,SF,ZF,PF,CF} |
| result | output | 16 | Operation result, held until next completion |
| wr_en | output | 1 | Result write-enable, pulses with done |
| flags_out | output | 5 | Updated flags {OF,SF,ZF,PF,CF} |
| busy | output | 1 | A shift or rotate is stepping |
| done | output | 1 | One-cycle completion pulse |

## Verification
Bitwise operations, zero-count shifts and undefined opcodes have their outputs due at the first clock edge after the start cycle. A shift or rotate of n steps is due at edge n+1. The bench drives `start` on a falling edge and counts rising edges for the expected latency. It samples on the falling edge after each edge and confirms that `done` is low in every earlier cycle before it compares `result`, `wr_en` and `flags_out` with a bit-serial reference model. One directed case raises `start` in the middle of a rotate and checks that neither the result nor the `done` timing changes.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
   typedef enum logic [3:0] {
      OP_AND  = 4'd0,
      OP_OR   = 4'd1,
      OP_XOR  = 4'd2,
      OP_NOT  = 4'd3,
      OP_TEST = 4'd4,
      OP_SHL  = 4'd5,
      OP_SAL  = 4'd6,
      OP_SHR  = 4'd7,
      OP_SAR  = 4'd8,
      OP_ROL  = 4'd9,
      OP_ROR  = 4'd10,
      OP_RCL  = 4'd11,
      OP_RCR  = 4'd12,
      OP_U13  = 4'd13,
      OP_U14  = 4'd14,
      OP_U15  = 4'd15
   } bsu_op_e;

   localparam int NFLAGS = 5;
   localparam int F_CF = 0;
   localparam int F_PF = 1;
   localparam int F_ZF = 2;
   localparam int F_SF = 3;
   localparam int F_OF = 4;

   function automatic logic op_is_bitwise(bsu_op_e o);
      return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR) ||
             (o == OP_NOT) || (o == OP_TEST);
   endfunction

   function automatic logic op_is_step(bsu_op_e o);
      return (o >= OP_SHL) && (o <= OP_RCR);
   endfunction

   function automatic logic op_is_rotate(bsu_op_e o);
      return (o >= OP_ROL) && (o <= OP_RCR);
   endfunction

   function automatic logic op_is_leftward(bsu_op_e o);
      return (o == OP_SHL) || (o == OP_SAL) || (o == OP_ROL) || (o == OP_RCL);
   endfunction
endpackage

// File: rtl/bsu_logic.sv
module bsu_logic
   import bsu_pkg::*;
#(
   parameter int DW = 16
) (
   input  bsu_op_e          op,
   input  logic [DW-1:0]    a,
   input  logic [DW-1:0]    b,
   output logic [DW-1:0]    y
);
   always_comb begin
      unique case (op)
         OP_AND, OP_TEST: y = a & b;
         OP_OR:           y = a | b;
         OP_XOR:          y = a ^ b;
         OP_NOT:          y = ~a;
         default:         y = a;
      endcase
   end
endmodule

// File: rtl/bsu_szp.sv
module bsu_szp #(
   parameter int DW = 16,
   parameter int BW = 8
) (
   input  logic          wide,
   input  logic [DW-1:0] val,
   output logic          zf,
   output logic          sf,
   output logic          pf
);
   always_comb begin
      zf = wide ? (val == '0) : (val[BW-1:0] == '0);
      sf = wide ? val[DW-1] : val[BW-1];
      pf = ~^val[7:0];
   end
endmodule

// File: rtl/bsu_step.sv
module bsu_step
   import bsu_pkg::*;
#(
   parameter int DW = 16,
   parameter int BW = 8
) (
   input  bsu_op_e       op,
   input  logic          wide,
   input  logic [DW-1:0] val,
   input  logic          cin,
   output logic [DW-1:0] val_n,
   output logic          cout
);
   // lane 0 = byte width, lane 1 = word width
   for (genvar g = 0; g < 2; g++) begin : g_lane
      localparam int W = (g == 0) ? BW : DW;
      logic [DW-1:0] lane_out;
      logic          lane_co;
      always_comb begin
         logic [W-1:0] lv;
         logic [W-1:0] nv;
         lv = val[W-1:0];
         unique case (op)
            OP_SHL, OP_SAL: begin nv = {lv[W-2:0], 1'b0};     lane_co = lv[W-1]; end
            OP_SHR:         begin nv = {1'b0, lv[W-1:1]};     lane_co = lv[0];   end
            OP_SAR:         begin nv = {lv[W-1], lv[W-1:1]};  lane_co = lv[0];   end
            OP_ROL:         begin nv = {lv[W-2:0], lv[W-1]};  lane_co = lv[W-1]; end
            OP_ROR:         begin nv = {lv[0], lv[W-1:1]};    lane_co = lv[0];   end
            OP_RCL:         begin nv = {lv[W-2:0], cin};      lane_co = lv[W-1]; end
            OP_RCR:         begin nv = {cin, lv[W-1:1]};      lane_co = lv[0];   end
            default:        begin nv = lv;                    lane_co = cin;     end
         endcase
         lane_out = DW'(nv);
      end
   end

   assign val_n = wide ? g_lane[1].lane_out : g_lane[0].lane_out;
   assign cout  = wide ? g_lane[1].lane_co  : g_lane[0].lane_co;
endmodule

// File: rtl/bitop_shift_unit.sv
module bitop_shift_unit
   import bsu_pkg::*;
#(
   parameter int DW     = 16,
   parameter int CNT_W  = 5,
   parameter int CREG_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        op,
   input  logic              is_word,
   input  logic [DW-1:0]     dst_in,
   input  logic [DW-1:0]     src_in,
   input  logic              cnt_sel,
   input  logic [CREG_W-1:0] cnt_reg,
   input  logic [NFLAGS-1:0] flags_in,
   output logic [DW-1:0]     result,
   output logic              wr_en,
   output logic [NFLAGS-1:0] flags_out,
   output logic              busy,
   output logic              done
);
   localparam int BW = DW / 2;

   if (DW < 16 || (DW % 2) != 0) begin : g_bad_dw
      $error("bitop_shift_unit: DW must be even and at least 16");
   end
   if (CREG_W < CNT_W || CNT_W < 1) begin : g_bad_cnt
      $error("bitop_shift_unit: CREG_W must cover CNT_W");
   end
   if (CREG_W > CNT_W) begin : g_cnt_hi
      logic unused_cnt_hi;
      assign unused_cnt_hi = ^cnt_reg[CREG_W-1:CNT_W];
   end

   function automatic logic [DW-1:0] size_cut(logic [DW-1:0] v, logic wide);
      return wide ? v : {{(DW-BW){1'b0}}, v[BW-1:0]};
   endfunction

   bsu_op_e             op_e, op_q;
   logic                word_q, cf_w, one_q;
   logic [NFLAGS-1:0]   fin_q;
   logic [DW-1:0]       work;
   logic [CNT_W-1:0]    rem, n_start;
   logic                start_ok;

   assign op_e     = bsu_op_e'(op);
   assign start_ok = start && !busy;
   assign n_start  = cnt_sel ? cnt_reg[CNT_W-1:0] : CNT_W'(1);

   // bitwise path
   logic [DW-1:0] lres, lres_m;
   logic          l_zf, l_sf, l_pf;
   bsu_logic #(.DW(DW)) u_logic (.op(op_e), .a(dst_in), .b(src_in), .y(lres));
   assign lres_m = size_cut(lres, is_word);
   bsu_szp #(.DW(DW), .BW(BW)) u_szp_l (
      .wide(is_word), .val(lres_m), .zf(l_zf), .sf(l_sf), .pf(l_pf));

   // stepping path
   logic [DW-1:0] st_val;
   logic          st_cf, s_zf, s_sf, s_pf, st_msb, st_msb2;
   bsu_step #(.DW(DW), .BW(BW)) u_step (
      .op(op_q), .wide(word_q), .val(work), .cin(cf_w),
      .val_n(st_val), .cout(st_cf));
   bsu_szp #(.DW(DW), .BW(BW)) u_szp_s (
      .wide(word_q), .val(st_val), .zf(s_zf), .sf(s_sf), .pf(s_pf));
   assign st_msb  = word_q ? st_val[DW-1] : st_val[BW-1];
   assign st_msb2 = word_q ? st_val[DW-2] : st_val[BW-2];

   logic [NFLAGS-1:0] fl_fin, fl_bit;
   always_comb begin
      fl_fin       = fin_q;
      fl_fin[F_CF] = st_cf;
      if (one_q)
         fl_fin[F_OF] = op_is_leftward(op_q) ? (st_msb ^ st_cf) : (st_msb ^ st_msb2);
      if (!op_is_rotate(op_q)) begin
         fl_fin[F_ZF] = s_zf;
         fl_fin[F_SF] = s_sf;
         fl_fin[F_PF] = s_pf;
      end
   end

   always_comb begin
      if (op_e == OP_NOT) begin
         fl_bit = flags_in;
      end else begin
         fl_bit       = '0;
         fl_bit[F_ZF] = l_zf;
         fl_bit[F_SF] = l_sf;
         fl_bit[F_PF] = l_pf;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         wr_en     <= 1'b0;
         result    <= '0;
         flags_out <= '0;
         work      <= '0;
         cf_w      <= 1'b0;
         rem       <= '0;
         one_q     <= 1'b0;
         op_q      <= OP_AND;
         word_q    <= 1'b0;
         fin_q     <= '0;
      end else begin
         done  <= 1'b0;
         wr_en <= 1'b0;
         if (start_ok) begin
            op_q   <= op_e;
            word_q <= is_word;
            fin_q  <= flags_in;
            if (op_is_bitwise(op_e)) begin
               result    <= lres_m;
               flags_out <= fl_bit;
               done      <= 1'b1;
               wr_en     <= (op_e != OP_TEST);
            end else if (op_is_step(op_e) && n_start != '0) begin
               busy  <= 1'b1;
               work  <= size_cut(dst_in, is_word);
               cf_w  <= flags_in[F_CF];
               rem   <= n_start;
               one_q <= (n_start == CNT_W'(1));
            end else begin
               result    <= size_cut(dst_in, is_word);
               flags_out <= flags_in;
               done      <= 1'b1;
               wr_en     <= op_is_step(op_e);
            end
         end else if (busy) begin
            work <= st_val;
            cf_w <= st_cf;
            rem  <= rem - CNT_W'(1);
            if (rem == CNT_W'(1)) begin
               busy      <= 1'b0;
               done      <= 1'b1;
               wr_en     <= 1'b1;
               result    <= st_val;
               flags_out <= fl_fin;
            end
         end
      end
   end

   // ---------------- assertions ----------------
   p_test_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done && op_q == OP_TEST |-> !wr_en);

   p_not_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done && op_q == OP_NOT |-> flags_out == fin_q);

   p_bitwise_cfof_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done && (op_q == OP_AND || op_q == OP_OR || op_q == OP_XOR || op_q == OP_TEST)
      |-> !flags_out[F_CF] && !flags_out[F_OF]);

   p_byte_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done && !word_q |-> result[DW-1:BW] == '0);

   p_step_rate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rem > CNT_W'(1) |=> busy && rem == $past(rem) - CNT_W'(1));

   p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> op_q == $past(op_q) && word_q == $past(word_q));

   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_rot_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (op_q == OP_ROL || op_q == OP_ROR) |=>
      $countones(work) == $countones($past(work)));
endmodule

// File: tb/tb_bitop_shift_unit.sv
module tb_bitop_shift_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  op = '0;
   logic        is_word = 1'b0;
   logic [15:0] dst_in = '0, src_in = '0;
   logic        cnt_sel = 1'b0;
   logic [7:0]  cnt_reg = '0;
   logic [4:0]  flags_in = '0;
   logic [15:0] result;
   logic        wr_en, busy, done;
   logic [4:0]  flags_out;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   bitop_shift_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_word(is_word),
      .dst_in(dst_in), .src_in(src_in), .cnt_sel(cnt_sel), .cnt_reg(cnt_reg),
      .flags_in(flags_in), .result(result), .wr_en(wr_en),
      .flags_out(flags_out), .busy(busy), .done(done));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [3:0] o);
      case (o)
         0, 1, 2: return "R1";
         3:       return "R2";
         4:       return "R3";
         5, 6:    return "R5";
         7:       return "R6";
         8:       return "R7";
         9, 10:   return "R8";
         11, 12:  return "R9";
         default: return "R14";
      endcase
   endfunction

   // flag layout: [0]carry [1]parity [2]zero [3]sign [4]overflow
   function automatic void ref_run(input logic [3:0] o, input bit w,
         input logic [15:0] d, input logic [15:0] s, input int n,
         input logic [4:0] fin, output logic [15:0] r,
         output logic [4:0] f, output bit we);
      logic [15:0] m;
      int hi;
      logic c, t;
      m = w ? 16'hFFFF : 16'h00FF;
      hi = w ? 15 : 7;
      f = fin; we = 1;
      case (o)
         0, 1, 2, 4: begin
            r = (o == 1) ? (d | s) : (o == 2) ? (d ^ s) : (d & s);
            r &= m;
            f = '0; f[2] = (r == 0); f[3] = r[hi]; f[1] = ~^r[7:0];
            we = (o != 4);
         end
         3: r = ~d & m;
         5, 6, 7, 8, 9, 10, 11, 12: begin
            r = d & m; c = fin[0];
            if (n > 0) begin
               for (int i = 0; i < n; i++) begin
                  case (o)
                     5, 6: begin t = r[hi]; r = (r << 1) & m; c = t; end
                     7:    begin c = r[0]; r = r >> 1; end
                     8:    begin t = r[hi]; c = r[0]; r = r >> 1; r[hi] = t; end
                     9:    begin t = r[hi]; r = ((r << 1) | {15'b0, t}) & m; c = t; end
                     10:   begin t = r[0]; r = r >> 1; r[hi] = t; c = t; end
                     11:   begin t = r[hi]; r = ((r << 1) | {15'b0, c}) & m; c = t; end
                     default: begin t = r[0]; r = r >> 1; r[hi] = c; c = t; end
                  endcase
               end
               f[0] = c;
               if (n == 1)
                  f[4] = (o == 5 || o == 6 || o == 9 || o == 11) ? (r[hi] ^ c)
                                                                 : (r[hi] ^ r[hi-1]);
               if (o <= 8) begin f[2] = (r == 0); f[3] = r[hi]; f[1] = ~^r[7:0]; end
            end
         end
         default: begin r = d & m; we = 0; end
      endcase
   endfunction

   task automatic run_op(input logic [3:0] o, input bit w, input logic [15:0] d,
                         input logic [15:0] s, input bit sel, input logic [7:0] creg,
                         input logic [4:0] fin, input string extra);
      int n, lat;
      logic [15:0] er; logic [4:0] ef; bit ewe;
      string rq;
      n = sel ? int'(creg[4:0]) : 1;
      lat = (o >= 5 && o <= 12 && n > 0) ? n + 1 : 1;
      ref_run(o, w, d, s, n, fin, er, ef, ewe);
      rq = (extra != "") ? extra : req_of(o);
      @(negedge clk);
      op = o; is_word = w; dst_in = d; src_in = s; cnt_sel = sel;
      cnt_reg = creg; flags_in = fin; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k < lat; k++) begin
         if (k == 1 || k == lat - 1)
            chk(done == 1'b0, "R11", "done early", 32'(done), 0);
         @(negedge clk);
      end
      chk(done == 1'b1, (lat > 1) ? "R11" : rq, "done timing", 32'(done), 1);
      chk(result == er, rq, "result", 32'(result), 32'(er));
      chk(flags_out == ef, (o >= 5 && o <= 12 && n > 0) ? "R13" : rq, "flags",
          32'(flags_out), 32'(ef));
      chk(wr_en == ewe, rq, "wr_en", 32'(wr_en), 32'(ewe));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 0 && wr_en == 0 && busy == 0 && result == 0, "R11", "reset state",
          {13'b0, done, wr_en, busy, result}, 0);

      // directed corners
      run_op(0, 1, 16'hF0F0, 16'h0FF0, 0, 0, 5'h1F, "R1");
      run_op(0, 0, 16'h1203, 16'hFF03, 0, 0, 5'h1F, "R4");   // 0x03: even parity
      run_op(1, 1, 16'h8000, 16'h0001, 0, 0, 5'h00, "R4");   // sign set
      run_op(2, 1, 16'hA5A5, 16'hA5A5, 0, 0, 5'h00, "R4");   // zero
      run_op(3, 1, 16'h1234, 0, 0, 0, 5'h15, "R2");
      run_op(4, 1, 16'h00F0, 16'h0010, 0, 0, 5'h1F, "R3");
      run_op(5, 1, 16'h4000, 0, 0, 0, 5'h00, "R5");          // OF set on count 1
      run_op(6, 1, 16'h4000, 0, 0, 0, 5'h00, "R5");          // same as opcode 5
      run_op(7, 0, 16'hFF81, 0, 1, 8'd3, 5'h00, "R6");
      run_op(8, 1, 16'h8001, 0, 0, 0, 5'h10, "R7");          // 0xC000, CF 1
      run_op(9, 0, 16'h0081, 0, 1, 8'd4, 5'h00, "R8");
      run_op(10, 1, 16'h0001, 0, 0, 0, 5'h00, "R8");
      run_op(11, 0, 16'h005A, 0, 1, 8'd9, 5'h01, "R9");      // 9-bit ring round trip
      run_op(12, 1, 16'h0002, 0, 1, 8'd2, 5'h01, "R9");
      run_op(5, 0, 16'hAB80, 0, 0, 0, 5'h00, "R10");         // byte MSB is bit 7
      run_op(8, 1, 16'h9000, 0, 1, 8'hE0, 5'h0B, "R12");     // low 5 bits are 0
      run_op(9, 1, 16'h8421, 0, 1, 8'd31, 5'h1A, "R13");     // count 31, OF kept
      run_op(14, 1, 16'h5555, 16'h1111, 0, 0, 5'h07, "R14");

      // start during busy is ignored (R11)
      @(negedge clk);
      op = 4'd9; is_word = 1; dst_in = 16'h0003; cnt_sel = 1; cnt_reg = 8'd6;
      flags_in = 0; start = 1;
      @(negedge clk); start = 0;
      @(negedge clk);
      op = 4'd0; dst_in = 16'h0000; src_in = 16'h0000; start = 1;
      @(negedge clk); start = 0;
      repeat (4) @(negedge clk);
      chk(done == 1 && result == 16'h00C0, "R11", "ignored start: result",
          32'(result), 32'h00C0);
      @(negedge clk);
      chk(done == 0, "R11", "ignored start: no extra done", 32'(done), 0);

      // constrained random
      void'($urandom(32'd20140915));
      for (int i = 0; i < 400; i++) begin
         logic [3:0] ro; logic [7:0] rc;
         ro = 4'($urandom_range(0, 15));
         rc = 8'($urandom_range(0, 255));
         run_op(ro, 1'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
                rc, 5'($urandom), "");
      end
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (150000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule